// File: doc/BRIEF.md
# Walking-Pattern Operand Sequencer

This block drives the two operands of a multiplier under test with a structured, non-exhaustive set of test vectors. It emits one operand pair per clock. The B operand walks through three families of patterns: a single set bit, two adjacent set bits, then three adjacent set bits. Each family starts at the most significant end and moves one position toward bit 0 per cycle. Together they give 3·(B_W−1) B values. That whole B list is replayed for every A value, and the A operand itself walks a single set bit from MSB to LSB. A run therefore lasts 3·A_W·(B_W−1) cycles, which is 36 for 4×4 and 168 for 8×8. An exhaustive sweep would need 2^(A_W+B_W) cycles.

A pulse on `start` begins a run. The level of `invert` at that moment selects complemented mode, in which both operands are the bitwise inverse of the normal patterns (walking zeros, walking zero pairs and walking zero triplets). The consumer takes an operand pair in every cycle in which `vld` is high. `done` marks the cycle after the last pair. Compaction of the multiplier response happens elsewhere.

Control is a three-state machine:
- ST_IDLE goes to ST_RUN on `start`.
- ST_RUN stays in ST_RUN until the final pair, then goes to ST_DONE.
- ST_DONE always returns to ST_IDLE after one cycle.

Top module: `mwp_walk_seq`

## Requirements
- R1: While reset is held and after its release, `vld`, `done`, `op_a` and `op_b` are all 0 until a start is accepted.
- R2: A `start` seen at a clock edge in ST_IDLE makes `vld` high from the next cycle onward, for exactly 3·A_W·(B_W−1) consecutive cycles.
- R3: For each A value, `op_b` takes these values in order. First come the B_W single-one patterns, starting at the MSB (1000, 0100, 0010, 0001 for 4 bits). Next come the B_W−1 adjacent-pair patterns (1100, 0110, 0011). Last come the B_W−2 triplet patterns (1110, 0111). Each pattern is shifted one bit toward the LSB per cycle.
- R4: `op_a` begins with only its MSB set. It holds each value for 3·(B_W−1) cycles and then moves its single one bit one place toward the LSB, ending at bit 0.
- R5: `done` is high for exactly one cycle, the cycle right after the last valid pair. `vld` is low in that cycle.
- R6: If `invert` is 1 when start is accepted, every `op_a` and `op_b` of that run is the bitwise inverse of the normal value. `invert` is ignored at all other times.
- R7: `start` is ignored in ST_RUN and ST_DONE. The run in progress keeps its order, its mode and its length, and no new run follows.
- R8: In every cycle in which `vld` is low, `op_a` and `op_b` are 0.
- R9: While `vld` is high, `op_a` has either exactly one bit set or exactly one bit clear. `op_b` has 1 to 3 bits set, or 1 to 3 bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| invert | input | 1 | Complemented-mode select, sampled with an accepted start |
| vld | output | 1 | An operand pair is presented this cycle |
| op_a | output | A_W | A operand |
| op_b | output | B_W | B operand |
| done | output | 1 | One-cycle pulse after the last pair |

## Verification
The checker verifies four things on every cycle: that a run lasts exactly the vector count, that `done` follows the falling edge of `vld` for a single cycle, that the operands are zero outside a run, and the bit-weight shape of each operand. The exact order of pairs cannot be shown by a property, so only the bench scenarios demonstrate it. These scenarios cover the order for two widths in normal and complemented mode, the latching of `invert`, and the rejection of a start in the middle of a run or in the done cycle.

// File: rtl/mwp_pkg.sv
package mwp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mwp_state_e;

    // Number of adjacent ones in the walking B seed.
    typedef enum logic [1:0] {
        RW_ONE   = 2'd1,
        RW_TWO   = 2'd2,
        RW_THREE = 2'd3
    } run_w_e;

    function automatic int unsigned vec_total(input int unsigned aw, input int unsigned bw);
        return 3 * aw * (bw - 1);
    endfunction

endpackage

// File: rtl/mwp_b_walker.sv
module mwp_b_walker
    import mwp_pkg::*;
#(
    parameter int unsigned B_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step,
    output logic [B_W-1:0] pat,
    output logic           last
);
    localparam int unsigned SH_W = (B_W > 1) ? $clog2(B_W) : 1;

    typedef logic [B_W-1:0] bvec_t;

    // Seeds: one, two and three adjacent ones at the MSB end.
    bvec_t seed [3];
    logic [SH_W-1:0] lim [3];

    for (genvar w = 1; w <= 3; w++) begin : g_seed
        assign seed[w-1] = bvec_t'((1 << w) - 1) << (B_W - w);
        assign lim[w-1]  = SH_W'(B_W - w);
    end

    run_w_e          width_q;
    logic [SH_W-1:0] shift_q;
    bvec_t           cur_seed;
    logic [SH_W-1:0] cur_lim;
    logic            at_end;

    always_comb begin
        unique case (width_q)
            RW_ONE:   begin cur_seed = seed[0]; cur_lim = lim[0]; end
            RW_TWO:   begin cur_seed = seed[1]; cur_lim = lim[1]; end
            RW_THREE: begin cur_seed = seed[2]; cur_lim = lim[2]; end
            default:  begin cur_seed = seed[0]; cur_lim = lim[0]; end
        endcase
    end

    assign at_end = (shift_q == cur_lim);
    assign pat    = cur_seed >> shift_q;
    assign last   = at_end && (width_q == RW_THREE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= RW_ONE;
            shift_q <= '0;
        end else if (clear) begin
            width_q <= RW_ONE;
            shift_q <= '0;
        end else if (step) begin
            if (at_end) begin
                shift_q <= '0;
                unique case (width_q)
                    RW_ONE:   width_q <= RW_TWO;
                    RW_TWO:   width_q <= RW_THREE;
                    default:  width_q <= RW_ONE;
                endcase
            end else begin
                shift_q <= shift_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mwp_a_walker.sv
module mwp_a_walker #(
    parameter int unsigned A_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step,
    output logic [A_W-1:0] pat,
    output logic           last
);
    localparam int unsigned PA_W = (A_W > 1) ? $clog2(A_W) : 1;
    localparam logic [A_W-1:0] MSB_ONE = {1'b1, {(A_W-1){1'b0}}};
    localparam logic [PA_W-1:0] POS_END = PA_W'(A_W - 1);

    logic [PA_W-1:0] pos_q;

    assign pat  = MSB_ONE >> pos_q;
    assign last = (pos_q == POS_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clear) begin
            pos_q <= '0;
        end else if (step) begin
            pos_q <= last ? '0 : pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/mwp_walk_seq.sv
module mwp_walk_seq
    import mwp_pkg::*;
#(
    parameter int unsigned A_W = 4,
    parameter int unsigned B_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           invert,
    output logic           vld,
    output logic [A_W-1:0] op_a,
    output logic [B_W-1:0] op_b,
    output logic           done
);
    mwp_state_e     state_q;
    mwp_state_e     state_d;
    logic           inv_q;
    logic           accept;
    logic           step_b;
    logic           step_a;
    logic           b_last;
    logic           a_last;
    logic [A_W-1:0] a_pat;
    logic [B_W-1:0] b_pat;

    assign accept = (state_q == ST_IDLE) && start;
    assign step_b = (state_q == ST_RUN);
    assign step_a = step_b && b_last;

    mwp_a_walker #(.A_W(A_W)) u_a_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (step_a),
        .pat   (a_pat),
        .last  (a_last)
    );

    mwp_b_walker #(.B_W(B_W)) u_b_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (step_b),
        .pat   (b_pat),
        .last  (b_last)
    );

    // State register and mode latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            inv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                inv_q <= invert;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)           state_d = ST_RUN;
            ST_RUN:  if (a_last && b_last) state_d = ST_DONE;
            ST_DONE:                      state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        vld  = (state_q == ST_RUN);
        done = (state_q == ST_DONE);
        op_a = '0;
        op_b = '0;
        if (vld) begin
            op_a = a_pat ^ {A_W{inv_q}};
            op_b = b_pat ^ {B_W{inv_q}};
        end
    end

endmodule

// File: rtl/mwp_walk_chk.sv
module mwp_walk_chk
    import mwp_pkg::*;
#(
    parameter int unsigned A_W = 4,
    parameter int unsigned B_W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           vld,
    input logic [A_W-1:0] op_a,
    input logic [B_W-1:0] op_b,
    input logic           done
);
    localparam int unsigned TOTAL = vec_total(A_W, B_W);
    localparam int unsigned CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   run_cnt <= '0;
        else if (vld) run_cnt <= run_cnt + 1'b1;
        else          run_cnt <= '0;
    end

    // R2: run length
    a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vld) |-> (run_cnt == CW'(TOTAL)));
    a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (run_cnt < CW'(TOTAL)));
    a_r2_rise_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld) |-> $past(start));

    // R5: done pulse
    a_r5_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vld) |-> done);
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !vld));
    a_r5_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !vld);

    // R8: quiet operands
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> (op_a == '0 && op_b == '0));

    // R9: operand weight
    a_r9_a_weight: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ($countones(op_a) == 1 || $countones(op_a) == A_W - 1));
    a_r9_b_weight: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (($countones(op_b) >= 1 && $countones(op_b) <= 3) ||
                 ($countones(op_b) >= B_W - 3 && $countones(op_b) <= B_W - 1)));

    // R7: start within a run does not end it early
    a_r7_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && start && run_cnt < CW'(TOTAL - 1)) |=> vld);

endmodule

bind mwp_walk_seq mwp_walk_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .vld   (vld),
    .op_a  (op_a),
    .op_b  (op_b),
    .done  (done)
);

// File: tb/mwp_walk_seq_tb.sv
module mwp_walk_seq_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start4 = 1'b0, invert4 = 1'b0;
    logic start8 = 1'b0, invert8 = 1'b0;
    logic vld4, done4, vld8, done8;
    logic [3:0] a4, b4;
    logic [7:0] a8, b8;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mwp_walk_seq #(.A_W(4), .B_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start4), .invert(invert4),
        .vld(vld4), .op_a(a4), .op_b(b4), .done(done4));

    mwp_walk_seq #(.A_W(8), .B_W(8)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .start(start8), .invert(invert8),
        .vld(vld8), .op_a(a8), .op_b(b8), .done(done8));

    // Reference lists for the 4x4 run (R3, R4).
    localparam logic [3:0] B_REF [9] = '{
        4'b1000, 4'b0100, 4'b0010, 4'b0001,
        4'b1100, 4'b0110, 4'b0011,
        4'b1110, 4'b0111 };
    localparam logic [3:0] A_REF [4] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] b8_exp(input int idx);
        int w, s;
        logic [7:0] v = '0;
        if (idx < 8)       begin w = 1; s = idx;      end
        else if (idx < 15) begin w = 2; s = idx - 8;  end
        else               begin w = 3; s = idx - 15; end
        for (int k = 0; k < w; k++) v[7 - s - k] = 1'b1;
        return v;
    endfunction

    task automatic run4(input logic m, input bit poke);
        @(negedge clk); start4 = 1'b1; invert4 = m;
        @(negedge clk); start4 = 1'b0; invert4 = ~m;
        for (int k = 0; k < 36; k++) begin
            logic [3:0] ea, eb;
            ea = A_REF[k / 9] ^ {4{m}};
            eb = B_REF[k % 9] ^ {4{m}};
            chk(vld4 == 1'b1, "R2 vld4", vld4, 1);
            chk(a4 == ea, m ? "R6 R4 op_a" : "R4 op_a", a4, ea);
            chk(b4 == eb, m ? "R6 R3 op_b" : "R3 op_b", b4, eb);
            start4 = (poke && (k == 10 || k == 35)) ? 1'b1 : 1'b0; // R7
            @(negedge clk);
        end
        start4 = poke;                          // R7: start in done cycle
        chk(done4 == 1'b1 && vld4 == 1'b0, "R5 done4", {done4, vld4}, 2'b10);
        @(negedge clk); start4 = 1'b0;
        chk(done4 == 1'b0 && vld4 == 1'b0, "R7 R5 after done", {done4, vld4}, 0);
        chk(a4 == 4'd0 && b4 == 4'd0, "R8 quiet", {a4, b4}, 0);
        @(negedge clk);
        chk(vld4 == 1'b0, "R7 no restart", vld4, 0);
    endtask

    task automatic run8(input logic m);
        int cnt = 0;
        @(negedge clk); start8 = 1'b1; invert8 = m;
        @(negedge clk); start8 = 1'b0; invert8 = 1'b0;
        for (int k = 0; k < 168; k++) begin
            logic [7:0] ea, eb;
            ea = (8'h80 >> (k / 21)) ^ {8{m}};
            eb = b8_exp(k % 21) ^ {8{m}};
            if (vld8) cnt++;
            chk(a8 == ea, "R4 op_a wide", a8, ea);
            chk(b8 == eb, "R3 op_b wide", b8, eb);
            @(negedge clk);
        end
        chk(cnt == 168 && vld8 == 1'b0, "R2 wide count", cnt, 168);
        chk(done8 == 1'b1, "R5 done8", done8, 1);
        @(negedge clk);
        chk(done8 == 1'b0, "R5 done8 single", done8, 0);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(vld4 == 0 && done4 == 0 && a4 == 0 && b4 == 0, "R1 in reset", {vld4, done4, a4, b4}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(vld4 == 0 && done4 == 0 && vld8 == 0 && a8 == 0 && b8 == 0, "R1 after reset",
            {vld4, done4, vld8}, 0);
        run4(1'b0, 1'b0);
        run4(1'b1, 1'b0);
        run4(1'b0, 1'b1);
        run8(1'b0);
        run8(1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule